// File: doc/BRIEF.md
# Serial Line Format Decoder and Oversampling Rate Generator

This block serves a serial transmitter and receiver pair. It turns the contents of a line-format register into the frame parameters the shifters need: how many data bits, whether a parity bit is sent and which sense it has, how many stop bits follow, and the total number of bit times in one character. It also derives, from a reference clock, a tick at sixteen times the bit rate and a strobe that marks the end of every bit period.

The rate comes from a 16-bit integer divisor and a 3-bit fraction. One bit period lasts 16*(DIV+1)+FRAC reference clocks. The fraction is spread over the bit: the first FRAC of the sixteen sub-ticks are one clock longer than the rest. All three settings are presented together with a single write strobe. A write whose integer divisor is zero is discarded. The generator therefore stays silent from reset until the first write with a non-zero divisor. When a new rate is written while the generator runs, the new rate starts at the next bit boundary, so the bit in progress keeps its length.

Top module: `uart_baud_frame`

## Requirements
- R1: The decoded data length equals lineCtrl[1:0] plus 5, so it runs from 5 to 8.
- R2: lineCtrl[2] set gives two stop bits; clear gives one.
- R3: lineCtrl[5] set enables parity. With parity enabled, a set bit in lineCtrl[4:3] selects even parity and both bits clear select odd.
- R4: frameBits equals 1 start bit, plus the data bits, plus 1 when parity is enabled, plus the stop bits.
- R5: Frame outputs change only in the cycle after an accepted write strobe. Changing lineCtrl with cfgWe low has no effect.
- R6: A write with divInt equal to 0 is discarded entirely, for both frame and rate. No overTick appears until the first write with a non-zero divisor.
- R7: While running, the spacing between successive bitTick pulses is 16*(divInt+1)+divFrac clocks. Each bitTick coincides with every sixteenth overTick.
- R8: Within a bit, sub-ticks 0 to divFrac-1 last divInt+2 clocks and the others last divInt+1 clocks.
- R9: A rate written while the generator runs takes effect at the next bit boundary. The bit in progress completes at the old length.
- R10: After reset, both ticks are low and the frame outputs read 5 data bits, no parity, odd sense, 1 stop bit and a frame length of 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | One-cycle strobe: the three setting values are being written |
| lineCtrl | input | 6 | Line-format value: [1:0] length, [2] stop, [5:3] parity field |
| divInt | input | 16 | Integer rate divisor |
| divFrac | input | 3 | Fractional rate adjustment in clocks per bit |
| overTick | output | 1 | One-clock pulse at the end of each sub-tick |
| bitTick | output | 1 | One-clock pulse at the end of each bit period |
| dataBits | output | 4 | Decoded data length, 5 to 8 |
| parityEn | output | 1 | Parity bit present |
| parityEven | output | 1 | Even parity when set, odd when clear |
| stopBits | output | 2 | Stop bit count, 1 or 2 |
| frameBits | output | 4 | Total bit times per character |

## Verification
Some properties are checked on every cycle:
- the legal ranges of the data and stop counts and the frame-length sum;
- that the frame outputs hold still except right after an accepted write, and that a zero-divisor write leaves them untouched;
- silence before the first valid rate;
- that a bitTick always lands on every sixteenth overTick.

Other behaviour depends on clock counts that only measured stimulus can reveal, so the bench scenarios cover it:
- the exact bit-period length;
- the uneven spread of the fraction over the sub-ticks;
- the deferral of a rate change to the bit boundary;
- that a running rate survives a zero-divisor write.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

  localparam int LC_W   = 6;
  localparam int DLEN_W = 4;
  localparam int STOP_W = 2;
  localparam int FLEN_W = 4;

  typedef struct packed {
    logic rateLoad;   // copy pending rate into the active counters
    logic restart;    // counters start from sub-tick 0
  } genStrobe_t;

  typedef struct packed {
    logic [DLEN_W-1:0] dataBits;
    logic              parityEn;
    logic              parityEven;
    logic [STOP_W-1:0] stopBits;
    logic [FLEN_W-1:0] frameBits;
  } frameCfg_t;

  localparam frameCfg_t FRAME_RESET = '{
    dataBits:   DLEN_W'(5),
    parityEn:   1'b0,
    parityEven: 1'b0,
    stopBits:   STOP_W'(1),
    frameBits:  FLEN_W'(7)
  };

  function automatic frameCfg_t decodeFrame(input logic [LC_W-1:0] lc);
    frameCfg_t f;
    f.dataBits   = DLEN_W'(lc[1:0]) + DLEN_W'(5);
    f.stopBits   = lc[2] ? STOP_W'(2) : STOP_W'(1);
    f.parityEn   = lc[5];
    f.parityEven = lc[5] & (lc[4] | lc[3]);
    f.frameBits  = FLEN_W'(1) + f.dataBits + FLEN_W'(f.parityEn)
                 + FLEN_W'(f.stopBits);
    return f;
  endfunction

endpackage

// File: rtl/uart_baud_ctrl.sv
module uart_baud_ctrl
  import uart_baud_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [LC_W-1:0]   lineCtrl,
  input  logic [DIV_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic              bitEnd,
  output genStrobe_t        strobe,
  output logic [DIV_W-1:0]  pendDiv,
  output logic [FRAC_W-1:0] pendFrac,
  output frameCfg_t         frame
);

  logic validWr;
  logic pendValid;
  logic genActive;

  assign validWr = cfgWe && (divInt != '0);

  always_comb begin
    strobe.rateLoad = pendValid && (!genActive || bitEnd);
    strobe.restart  = pendValid && !genActive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frame     <= FRAME_RESET;
      pendDiv   <= '0;
      pendFrac  <= '0;
      pendValid <= 1'b0;
      genActive <= 1'b0;
    end else begin
      if (validWr) begin
        frame     <= decodeFrame(lineCtrl);
        pendDiv   <= divInt;
        pendFrac  <= divFrac;
        pendValid <= 1'b1;
      end else if (strobe.rateLoad) begin
        pendValid <= 1'b0;
      end
      if (strobe.rateLoad) begin
        genActive <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_baud_dp.sv
module uart_baud_dp
  import uart_baud_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FRAC_W     = 3,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  genStrobe_t        strobe,
  input  logic [DIV_W-1:0]  pendDiv,
  input  logic [FRAC_W-1:0] pendFrac,
  output logic              overTick,
  output logic              bitTick
);

  localparam int CNT_W = DIV_W + 1;
  localparam int SUB_W = $clog2(OVERSAMPLE);

  logic [DIV_W-1:0]  actDiv;
  logic [FRAC_W-1:0] actFrac;
  logic              running;
  logic [CNT_W-1:0]  clkCnt;
  logic [SUB_W-1:0]  subCnt;
  logic              stretch;
  logic [CNT_W-1:0]  lastCnt;
  logic              subEnd;
  logic              lastSub;

  always_comb begin
    stretch  = 32'(subCnt) < 32'(actFrac);
    lastCnt  = CNT_W'(actDiv) + CNT_W'(stretch);
    subEnd   = running && (clkCnt == lastCnt);
    lastSub  = 32'(subCnt) == OVERSAMPLE - 1;
    overTick = subEnd;
    bitTick  = subEnd && lastSub;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actDiv  <= '0;
      actFrac <= '0;
      running <= 1'b0;
      clkCnt  <= '0;
      subCnt  <= '0;
    end else begin
      if (strobe.rateLoad) begin
        actDiv  <= pendDiv;
        actFrac <= pendFrac;
        running <= 1'b1;
      end
      if (strobe.restart) begin
        clkCnt <= '0;
        subCnt <= '0;
      end else if (running) begin
        if (subEnd) begin
          clkCnt <= '0;
          subCnt <= lastSub ? '0 : subCnt + SUB_W'(1);
        end else begin
          clkCnt <= clkCnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/uart_baud_frame.sv
module uart_baud_frame
  import uart_baud_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FRAC_W     = 3,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [LC_W-1:0]   lineCtrl,
  input  logic [DIV_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  output logic              overTick,
  output logic              bitTick,
  output logic [DLEN_W-1:0] dataBits,
  output logic              parityEn,
  output logic              parityEven,
  output logic [STOP_W-1:0] stopBits,
  output logic [FLEN_W-1:0] frameBits
);

  genStrobe_t        strobe;
  logic [DIV_W-1:0]  pendDiv;
  logic [FRAC_W-1:0] pendFrac;
  frameCfg_t         frame;

  uart_baud_ctrl #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .lineCtrl(lineCtrl),
    .divInt(divInt), .divFrac(divFrac), .bitEnd(bitTick),
    .strobe(strobe), .pendDiv(pendDiv), .pendFrac(pendFrac), .frame(frame)
  );

  uart_baud_dp #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .OVERSAMPLE(OVERSAMPLE)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pendDiv(pendDiv),
    .pendFrac(pendFrac), .overTick(overTick), .bitTick(bitTick)
  );

  assign dataBits   = frame.dataBits;
  assign parityEn   = frame.parityEn;
  assign parityEven = frame.parityEven;
  assign stopBits   = frame.stopBits;
  assign frameBits  = frame.frameBits;

endmodule

// File: rtl/uart_baud_frame_chk.sv
module uart_baud_frame_chk
  import uart_baud_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [DIV_W-1:0]  divInt,
  input logic              overTick,
  input logic              bitTick,
  input logic [DLEN_W-1:0] dataBits,
  input logic              parityEn,
  input logic              parityEven,
  input logic [STOP_W-1:0] stopBits,
  input logic [FLEN_W-1:0] frameBits
);

  localparam int SUB_W = $clog2(OVERSAMPLE);

  logic             seenRate;
  logic [SUB_W-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenRate <= 1'b0;
      tickCnt  <= '0;
    end else begin
      if (cfgWe && divInt != '0) seenRate <= 1'b1;
      if (overTick) tickCnt <= (32'(tickCnt) == OVERSAMPLE - 1) ? '0 : tickCnt + SUB_W'(1);
    end
  end

  assert_data_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    dataBits >= DLEN_W'(5) && dataBits <= DLEN_W'(8));

  assert_stop_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    stopBits == STOP_W'(1) || stopBits == STOP_W'(2));

  assert_odd_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    !parityEn |-> !parityEven);

  assert_frame_sum_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameBits == FLEN_W'(1) + dataBits + FLEN_W'(parityEn) + FLEN_W'(stopBits));

  assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgWe) |-> $stable(dataBits) && $stable(parityEn) && $stable(parityEven)
                      && $stable(stopBits) && $stable(frameBits));

  assert_zero_div_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe && divInt == '0 |=> $stable(dataBits) && $stable(parityEn)
                              && $stable(stopBits) && $stable(frameBits));

  assert_idle_before_rate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !seenRate |-> !overTick && !bitTick);

  assert_bit_on_sub_R7: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> overTick);

  assert_bit_every16_R7: assert property (@(posedge clk) disable iff (!rstN)
    overTick && 32'(tickCnt) == OVERSAMPLE - 1 |-> bitTick);

endmodule

bind uart_baud_frame uart_baud_frame_chk #(.DIV_W(DIV_W), .OVERSAMPLE(OVERSAMPLE)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .divInt(divInt),
  .overTick(overTick), .bitTick(bitTick), .dataBits(dataBits),
  .parityEn(parityEn), .parityEven(parityEven), .stopBits(stopBits),
  .frameBits(frameBits)
);

// File: tb/tb_uart_baud_frame.sv
`timescale 1ns/1ps
module tb_uart_baud_frame;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [5:0]  lineCtrl = '0;
  logic [15:0] divInt = '0;
  logic [2:0]  divFrac = '0;
  logic        overTick, bitTick, parityEn, parityEven;
  logic [3:0]  dataBits, frameBits;
  logic [1:0]  stopBits;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  uart_baud_frame dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .lineCtrl(lineCtrl),
    .divInt(divInt), .divFrac(divFrac), .overTick(overTick), .bitTick(bitTick),
    .dataBits(dataBits), .parityEn(parityEn), .parityEven(parityEven),
    .stopBits(stopBits), .frameBits(frameBits)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cfgWrite(input logic [5:0] lc, input logic [15:0] di, input logic [2:0] fr);
    lineCtrl = lc; divInt = di; divFrac = fr; cfgWe = 1'b1;
    step();
    cfgWe = 1'b0;
  endtask

  task automatic waitBit();
    for (int i = 0; i < 5000; i++) begin
      step();
      if (bitTick) return;
    end
    chk("R7 bitTick timeout", 0, 1);
  endtask

  task automatic measureBit(output int len, output int subs);
    len = 0; subs = 0;
    for (int i = 0; i < 5000; i++) begin
      step();
      len++;
      if (overTick) subs++;
      if (bitTick) return;
    end
  endtask

  task automatic checkFrame(input string req, input int db, input int pe,
                            input int ev, input int sb, input int fb);
    chk({req, " dataBits"}, dataBits, db);
    chk({req, " parityEn"}, parityEn, pe);
    chk({req, " parityEven"}, parityEven, ev);
    chk({req, " stopBits"}, stopBits, sb);
    chk({req, " frameBits"}, frameBits, fb);
  endtask

  task automatic testReset();
    chk("R10 overTick", overTick, 0);
    chk("R10 bitTick", bitTick, 0);
    checkFrame("R10", 5, 0, 0, 1, 7);
  endtask

  task automatic testZeroIdle();
    int ticks = 0;
    for (int i = 0; i < 100; i++) begin step(); if (overTick) ticks++; end
    chk("R6 idle after reset", ticks, 0);
    cfgWrite(6'h3F, 16'd0, 3'd5);
    checkFrame("R6 zero-divisor write", 5, 0, 0, 1, 7);
    ticks = 0;
    for (int i = 0; i < 200; i++) begin step(); if (overTick) ticks++; end
    chk("R6 still idle", ticks, 0);
  endtask

  task automatic testDecode();
    cfgWrite(6'h03, 16'd1, 3'd0); checkFrame("R1 eight bits", 8, 0, 0, 1, 10);
    cfgWrite(6'h04, 16'd1, 3'd0); checkFrame("R2 two stops", 5, 0, 0, 2, 8);
    cfgWrite(6'h20, 16'd1, 3'd0); checkFrame("R3 odd", 5, 1, 0, 1, 8);
    cfgWrite(6'h28, 16'd1, 3'd0); checkFrame("R3 even bit3", 5, 1, 1, 1, 8);
    cfgWrite(6'h32, 16'd1, 3'd0); checkFrame("R3 even bit4", 7, 1, 1, 1, 10);
    cfgWrite(6'h18, 16'd1, 3'd0); checkFrame("R3 field without enable", 5, 0, 0, 1, 7);
    cfgWrite(6'h27, 16'd1, 3'd0); checkFrame("R4 longest", 8, 1, 0, 2, 12);
  endtask

  task automatic testNoStrobe();
    lineCtrl = 6'h00; divInt = 16'd9; divFrac = 3'd1;
    for (int i = 0; i < 10; i++) step();
    checkFrame("R5 no strobe", 8, 1, 0, 2, 12);
  endtask

  task automatic testPeriod();
    int len, subs;
    cfgWrite(6'h27, 16'd1, 3'd0);
    waitBit(); waitBit();
    measureBit(len, subs);
    chk("R7 period div1", len, 32);
    chk("R7 subticks per bit", subs, 16);
    cfgWrite(6'h27, 16'd2, 3'd3);
    waitBit(); waitBit();
    for (int k = 0; k < 16; k++) begin
      int n = 0;
      for (int i = 0; i < 100; i++) begin step(); n++; if (overTick) break; end
      chk($sformatf("R8 subtick %0d length", k), n, (k < 3) ? 4 : 3);
    end
    chk("R7 bit end after 16 subticks", bitTick, 1);
    measureBit(len, subs);
    chk("R7 period div2 frac3", len, 51);
  endtask

  task automatic testDeferred();
    int len = 0, subs;
    cfgWrite(6'h27, 16'd1, 3'd0);
    waitBit(); waitBit();
    for (int i = 1; i < 5000; i++) begin
      step(); len++;
      if (i == 5) begin divInt = 16'd3; divFrac = 3'd0; cfgWe = 1'b1; end
      if (i == 6) cfgWe = 1'b0;
      if (bitTick) break;
    end
    chk("R9 current bit keeps old length", len, 32);
    measureBit(len, subs);
    chk("R9 next bit uses new length", len, 64);
  endtask

  task automatic testZeroRunning();
    int len = 0, subs;
    waitBit();
    for (int i = 1; i < 5000; i++) begin
      step(); len++;
      if (i == 7) begin lineCtrl = 6'h00; divInt = 16'd0; divFrac = 3'd5; cfgWe = 1'b1; end
      if (i == 8) cfgWe = 1'b0;
      if (bitTick) break;
    end
    chk("R6 running bit unaffected", len, 64);
    measureBit(len, subs);
    chk("R6 rate kept after zero write", len, 64);
    checkFrame("R6 frame kept", 8, 1, 0, 2, 12);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    step(); step(); step();
    testReset();
    rstN = 1'b1;
    step();
    testReset();
    testZeroIdle();
    testDecode();
    testNoStrobe();
    testPeriod();
    testDeferred();
    testZeroRunning();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule